// File: doc/BRIEF.md
# SDRAM Presence-Detect Image Decoder

This block receives the 256-byte presence-detect image of an SDRAM module as a stream of beats. Each beat carries one byte and its index. While the stream arrives, the block keeps the bytes it needs and adds up the bytes covered by the checksum. A memory controller can then take the module's geometry, its supported bursts and latencies, and its key timings from the outputs, with the timings already expressed in controller clocks.

The beat with index 255 ends the stream. The block then checks two things: the memory-type byte and the checksum. If both are good, it converts four nanosecond timings into clock counts, one after another. Each conversion is a fixed-length subtract loop run against the configured clock period, given in tenths of a nanosecond. When the last conversion is done, all results are published together with a one-cycle `done`. If the image is rejected, the published values stay as they were, the error flag is raised, and `done` still pulses.

The controller is built around seven named states:
- `ST_COLLECT` takes in beats.
- `ST_VERIFY` judges the image.
- `ST_LOAD` primes the converter with the next timing.
- `ST_ITER` runs the subtract loop.
- `ST_STORE` keeps the count.
- `ST_COMMIT` publishes the results.
- `ST_REJECT` flags the error.

The transitions are:
- COLLECT→VERIFY on a beat with index 255.
- VERIFY→LOAD when the image is good, and VERIFY→REJECT when it is not.
- LOAD→ITER always.
- ITER→STORE after the last iteration.
- STORE→LOAD while timings remain, and STORE→COMMIT after the fourth.
- COMMIT→COLLECT and REJECT→COLLECT always.

Top module: `spd_decoder`

## Requirements
- R1: After reset, every output is zero, including `done`, `csum_ok` and `dec_err`.
- R2: The checksum is the low 8 bits of the sum of bytes 0 to 62, compared with byte 63. On a mismatch, `done` pulses with `csum_ok`=0 and `dec_err`=1. A published result with `dec_err`=0 always has `csum_ok`=1.
- R3: A byte 2 other than 0x04 (SDRAM) rejects the image. `dec_err`=1, and `csum_ok` still reports the checksum comparison.
- R4: On a rejected image, every decoded output keeps its previous value. Decoded outputs change only in the cycle in which `done` is high.
- R5: Geometry comes straight from the image. `row_bits` is byte 3, `col_bits` is byte 4, `rank_count` is byte 5 and `dev_banks` is byte 17. `ecc_present` is 1 exactly when byte 11 equals 0x02.
- R6: `burst_mask` is byte 16, where bit n means a burst of 2^n (0x0F = 1, 2, 4, 8). `cas_mask` is byte 18, where bit n means CAS latency n (0x06 = 2 and 3).
- R7: Bytes 9 and 23 are cycle times with whole nanoseconds in bits 7:4 and tenths in bits 3:0. They are output in tenths of a nanosecond as hi×10+lo, on `tck_cl3_tenths` and `tck_cl2_tenths`. For example, 0x75 gives 75.
- R8: Bytes 27 (`trp_clk`), 28 (`trrd_clk`), 29 (`trcd_clk`) and 30 (`tras_clk`) are nanoseconds. Each becomes ceil(ns×10 / `period_tenths`), capped at 16. A value of 0 ns gives 0.
- R9: `done` is a single-cycle pulse. It rises 74 clock edges after the edge that takes in beat 255 for an accepted image, and 2 edges after it for a rejected one.
- R10: Bytes 64 to 255, and bytes below 63 that are not decoded, have no effect on the decoded outputs beyond their part in the checksum.
- R11: Beats that arrive while a decode is in progress, including a beat with index 255, are ignored. They produce no extra `done` and do not alter the result.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| period_tenths | input | 8 | Controller clock period in tenths of ns, held stable during a decode |
| in_valid | input | 1 | Beat valid |
| in_index | input | 8 | Byte position of the beat |
| in_byte | input | 8 | Byte value of the beat |
| done | output | 1 | One-cycle pulse when a result is published |
| csum_ok | output | 1 | Checksum comparison of the last image |
| dec_err | output | 1 | Last image was rejected |
| row_bits | output | 8 | Row address bits |
| col_bits | output | 8 | Column address bits |
| rank_count | output | 8 | Module banks |
| dev_banks | output | 8 | Internal banks per device |
| ecc_present | output | 1 | Module carries check bits |
| burst_mask | output | 8 | Supported burst lengths bitmask |
| cas_mask | output | 8 | Supported CAS latencies bitmask |
| tck_cl3_tenths | output | 8 | Cycle time at highest CAS latency, tenths of ns |
| tck_cl2_tenths | output | 8 | Cycle time at second CAS latency, tenths of ns |
| trp_clk | output | 5 | Precharge time in clocks |
| trrd_clk | output | 5 | Row-to-row delay in clocks |
| trcd_clk | output | 5 | Row-to-column delay in clocks |
| tras_clk | output | 5 | Row active time in clocks |

## Verification
Every result appears a fixed number of edges after the edge that takes in beat 255: 74 for an accepted image and 2 for a rejected one. Nothing depends on the data values, because each conversion always runs its full sixteen iterations. The bench stamps the cycle of that final beat when it queues the expected item. The monitor, which samples on the falling edge, checks the measured delay against the predicted one whenever `done` is seen. Reject cases compare against the values left by the last accepted image. Beats sent during a decode must leave the expected queue in step, so any stray `done` shows up as an unexpected result.

// File: rtl/spd_pkg.sv
package spd_pkg;

    // Byte positions that the decoder interprets
    localparam logic [7:0] IX_TYPE     = 8'd2;
    localparam logic [7:0] IX_ROWS     = 8'd3;
    localparam logic [7:0] IX_COLS     = 8'd4;
    localparam logic [7:0] IX_RANKS    = 8'd5;
    localparam logic [7:0] IX_TCK_A    = 8'd9;
    localparam logic [7:0] IX_ECC      = 8'd11;
    localparam logic [7:0] IX_BURST    = 8'd16;
    localparam logic [7:0] IX_DBANKS   = 8'd17;
    localparam logic [7:0] IX_CAS      = 8'd18;
    localparam logic [7:0] IX_TCK_B    = 8'd23;
    localparam logic [7:0] IX_TRP      = 8'd27;
    localparam logic [7:0] IX_TRRD     = 8'd28;
    localparam logic [7:0] IX_TRCD     = 8'd29;
    localparam logic [7:0] IX_TRAS     = 8'd30;
    localparam logic [7:0] IX_SUM_LAST = 8'd62;
    localparam logic [7:0] IX_CSUM     = 8'd63;
    localparam logic [7:0] IX_FINAL    = 8'd255;

    localparam logic [7:0] TYPE_SDRAM  = 8'h04;
    localparam logic [7:0] ECC_CODE    = 8'h02;

    // Number of nanosecond timings converted serially
    localparam int NUM_T  = 4;
    localparam int FSEL_W = $clog2(NUM_T);

    typedef enum logic [2:0] {
        ST_COLLECT,
        ST_VERIFY,
        ST_LOAD,
        ST_ITER,
        ST_STORE,
        ST_COMMIT,
        ST_REJECT
    } dec_state_e;

    typedef struct packed {
        logic [7:0] mem_type;
        logic [7:0] rows;
        logic [7:0] cols;
        logic [7:0] ranks;
        logic [7:0] tck_a;
        logic [7:0] ecc;
        logic [7:0] burst;
        logic [7:0] dbanks;
        logic [7:0] cas;
        logic [7:0] tck_b;
        logic [7:0] trp;
        logic [7:0] trrd;
        logic [7:0] trcd;
        logic [7:0] tras;
        logic [7:0] csum_byte;
    } spd_raw_t;

endpackage

// File: rtl/spd_capture.sv
module spd_capture
    import spd_pkg::*;
(
    input  logic       clk,
    input  logic       rst_n,
    input  logic       en,
    input  logic       valid,
    input  logic [7:0] index,
    input  logic [7:0] data,
    output spd_raw_t   raw,
    output logic [7:0] sum
);

    // Keep only the interpreted bytes; accumulate the checksum span.
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            raw <= '0;
            sum <= '0;
        end else if (en && valid) begin
            case (index)
                IX_TYPE:   raw.mem_type  <= data;
                IX_ROWS:   raw.rows      <= data;
                IX_COLS:   raw.cols      <= data;
                IX_RANKS:  raw.ranks     <= data;
                IX_TCK_A:  raw.tck_a     <= data;
                IX_ECC:    raw.ecc       <= data;
                IX_BURST:  raw.burst     <= data;
                IX_DBANKS: raw.dbanks    <= data;
                IX_CAS:    raw.cas       <= data;
                IX_TCK_B:  raw.tck_b     <= data;
                IX_TRP:    raw.trp       <= data;
                IX_TRRD:   raw.trrd      <= data;
                IX_TRCD:   raw.trcd      <= data;
                IX_TRAS:   raw.tras      <= data;
                IX_CSUM:   raw.csum_byte <= data;
                default:   ;
            endcase
            if (index == 8'd0) begin
                sum <= data;
            end else if (index <= IX_SUM_LAST) begin
                sum <= sum + data;
            end
        end
    end

endmodule

// File: rtl/spd_tck_decode.sv
module spd_tck_decode (
    input  logic [7:0] code,
    output logic [7:0] tenths
);

    // Upper nibble whole ns, lower nibble tenths; max 15*10+15 fits 8 bits
    always_comb begin
        tenths = ({4'd0, code[7:4]} * 8'd10) + {4'd0, code[3:0]};
    end

endmodule

// File: rtl/spd_ns2clk.sv
module spd_ns2clk #(
    parameter int ITER_MAX = 16,
    parameter int CNT_W    = $clog2(ITER_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             step,
    input  logic [7:0]       ns_in,
    input  logic [7:0]       period,
    output logic [CNT_W-1:0] count
);

    localparam int REM_W = 12;

    logic [REM_W-1:0] rem;
    logic [REM_W-1:0] per_ext;

    assign per_ext = {{(REM_W-8){1'b0}}, period};

    // One subtraction per step; the count stops at zero remainder or the cap
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            rem   <= '0;
            count <= '0;
        end else if (load) begin
            rem   <= {{(REM_W-8){1'b0}}, ns_in} * REM_W'(10);
            count <= '0;
        end else if (step && (rem != '0) && (count < CNT_W'(ITER_MAX))) begin
            rem   <= (rem <= per_ext) ? '0 : (rem - per_ext);
            count <= count + CNT_W'(1);
        end
    end

endmodule

// File: rtl/spd_decoder.sv
module spd_decoder
    import spd_pkg::*;
#(
    parameter int ITER_MAX = 16,
    parameter int CNT_W    = $clog2(ITER_MAX + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic [7:0]       period_tenths,
    input  logic             in_valid,
    input  logic [7:0]       in_index,
    input  logic [7:0]       in_byte,
    output logic             done,
    output logic             csum_ok,
    output logic             dec_err,
    output logic [7:0]       row_bits,
    output logic [7:0]       col_bits,
    output logic [7:0]       rank_count,
    output logic [7:0]       dev_banks,
    output logic             ecc_present,
    output logic [7:0]       burst_mask,
    output logic [7:0]       cas_mask,
    output logic [7:0]       tck_cl3_tenths,
    output logic [7:0]       tck_cl2_tenths,
    output logic [CNT_W-1:0] trp_clk,
    output logic [CNT_W-1:0] trrd_clk,
    output logic [CNT_W-1:0] trcd_clk,
    output logic [CNT_W-1:0] tras_clk
);

    localparam int ITER_W = (ITER_MAX > 1) ? $clog2(ITER_MAX) : 1;

    dec_state_e          state, nxt;
    spd_raw_t            raw;
    logic [7:0]          sum;
    logic                type_ok, sum_match;
    logic [FSEL_W-1:0]   field_sel;
    logic [ITER_W-1:0]   iter_cnt;
    logic [7:0]          field_ns;
    logic [CNT_W-1:0]    conv_cnt;
    logic [7:0]          tck_a_dec, tck_b_dec;
    logic [NUM_T*CNT_W-1:0] stage_flat;

    // ---------------- capture and field decode ----------------
    spd_capture u_cap (
        .clk   (clk),
        .rst_n (rst_n),
        .en    (state == ST_COLLECT),
        .valid (in_valid),
        .index (in_index),
        .data  (in_byte),
        .raw   (raw),
        .sum   (sum)
    );

    spd_tck_decode u_tck_a (.code(raw.tck_a), .tenths(tck_a_dec));
    spd_tck_decode u_tck_b (.code(raw.tck_b), .tenths(tck_b_dec));

    assign type_ok   = (raw.mem_type == TYPE_SDRAM);
    assign sum_match = (sum == raw.csum_byte);

    // Field order of the serial conversion: precharge, row-row, row-col, active
    always_comb begin
        unique case (field_sel)
            2'd0:    field_ns = raw.trp;
            2'd1:    field_ns = raw.trrd;
            2'd2:    field_ns = raw.trcd;
            default: field_ns = raw.tras;
        endcase
    end

    spd_ns2clk #(
        .ITER_MAX (ITER_MAX),
        .CNT_W    (CNT_W)
    ) u_conv (
        .clk    (clk),
        .rst_n  (rst_n),
        .load   (state == ST_LOAD),
        .step   (state == ST_ITER),
        .ns_in  (field_ns),
        .period (period_tenths),
        .count  (conv_cnt)
    );

    // One staging slot per converted timing
    for (genvar g = 0; g < NUM_T; g++) begin : g_slot
        logic [CNT_W-1:0] slot;
        always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n) begin
                slot <= '0;
            end else if ((state == ST_STORE) && (field_sel == FSEL_W'(g))) begin
                slot <= conv_cnt;
            end
        end
        assign stage_flat[g*CNT_W +: CNT_W] = slot;
    end

    // ---------------- state register ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            state <= ST_COLLECT;
        end else begin
            state <= nxt;
        end
    end

    // ---------------- next state ----------------
    always_comb begin
        nxt = state;
        unique case (state)
            ST_COLLECT: if (in_valid && (in_index == IX_FINAL)) nxt = ST_VERIFY;
            ST_VERIFY:  nxt = (type_ok && sum_match) ? ST_LOAD : ST_REJECT;
            ST_LOAD:    nxt = ST_ITER;
            ST_ITER:    if (iter_cnt == ITER_W'(ITER_MAX - 1)) nxt = ST_STORE;
            ST_STORE:   nxt = (field_sel == FSEL_W'(NUM_T - 1)) ? ST_COMMIT : ST_LOAD;
            ST_COMMIT:  nxt = ST_COLLECT;
            ST_REJECT:  nxt = ST_COLLECT;
            default:    nxt = ST_COLLECT;
        endcase
    end

    // ---------------- sequencing counters ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            field_sel <= '0;
            iter_cnt  <= '0;
        end else begin
            unique case (state)
                ST_VERIFY: field_sel <= '0;
                ST_LOAD:   iter_cnt  <= '0;
                ST_ITER:   iter_cnt  <= iter_cnt + ITER_W'(1);
                ST_STORE:  field_sel <= field_sel + FSEL_W'(1);
                default:   ;
            endcase
        end
    end

    // ---------------- outputs ----------------
    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            done           <= 1'b0;
            csum_ok        <= 1'b0;
            dec_err        <= 1'b0;
            row_bits       <= '0;
            col_bits       <= '0;
            rank_count     <= '0;
            dev_banks      <= '0;
            ecc_present    <= 1'b0;
            burst_mask     <= '0;
            cas_mask       <= '0;
            tck_cl3_tenths <= '0;
            tck_cl2_tenths <= '0;
            trp_clk        <= '0;
            trrd_clk       <= '0;
            trcd_clk       <= '0;
            tras_clk       <= '0;
        end else begin
            done <= 1'b0;
            unique case (state)
                ST_COMMIT: begin
                    done           <= 1'b1;
                    csum_ok        <= 1'b1;
                    dec_err        <= 1'b0;
                    row_bits       <= raw.rows;
                    col_bits       <= raw.cols;
                    rank_count     <= raw.ranks;
                    dev_banks      <= raw.dbanks;
                    ecc_present    <= (raw.ecc == ECC_CODE);
                    burst_mask     <= raw.burst;
                    cas_mask       <= raw.cas;
                    tck_cl3_tenths <= tck_a_dec;
                    tck_cl2_tenths <= tck_b_dec;
                    trp_clk        <= stage_flat[0*CNT_W +: CNT_W];
                    trrd_clk       <= stage_flat[1*CNT_W +: CNT_W];
                    trcd_clk       <= stage_flat[2*CNT_W +: CNT_W];
                    tras_clk       <= stage_flat[3*CNT_W +: CNT_W];
                end
                ST_REJECT: begin
                    done    <= 1'b1;
                    csum_ok <= sum_match;
                    dec_err <= 1'b1;
                end
                default: ;
            endcase
        end
    end

endmodule

// File: rtl/spd_decoder_chk.sv
module spd_decoder_chk #(
    parameter int ITER_MAX = 16,
    parameter int CNT_W    = $clog2(ITER_MAX + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             done,
    input logic             dec_err,
    input logic             csum_ok,
    input logic [7:0]       row_bits,
    input logic [CNT_W-1:0] trp_clk,
    input logic [CNT_W-1:0] tras_clk
);

    assert_done_pulse_R9: assert property (@(posedge clk) disable iff (!rst_n)
        done |=> !done);

    assert_hold_on_reject_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (done && dec_err) |-> ($stable(row_bits) && $stable(trp_clk) && $stable(tras_clk)));

    assert_moves_only_at_done_R4: assert property (@(posedge clk) disable iff (!rst_n)
        (!$stable(row_bits) || !$stable(trp_clk) || !$stable(tras_clk)) |-> done);

    assert_accept_has_csum_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !dec_err) |-> csum_ok);

    assert_bad_csum_is_error_R2: assert property (@(posedge clk) disable iff (!rst_n)
        (done && !csum_ok) |-> dec_err);

    assert_count_capped_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (tras_clk <= CNT_W'(ITER_MAX)) && (trp_clk <= CNT_W'(ITER_MAX)));

endmodule

bind spd_decoder spd_decoder_chk #(
    .ITER_MAX (ITER_MAX),
    .CNT_W    (CNT_W)
) u_chk (
    .clk      (clk),
    .rst_n    (rst_n),
    .done     (done),
    .dec_err  (dec_err),
    .csum_ok  (csum_ok),
    .row_bits (row_bits),
    .trp_clk  (trp_clk),
    .tras_clk (tras_clk)
);

// File: tb/tb_spd_decoder.sv
`timescale 1ns/1ps
module tb_spd_decoder;

    localparam int ITER_MAX = 16;
    localparam int CNT_W    = 5;
    localparam int LAT_OK   = 2 + 4 * (ITER_MAX + 2);
    localparam int LAT_BAD  = 2;

    logic             clk = 1'b0;
    logic             rst_n = 1'b0;
    logic [7:0]       period_tenths = 8'd75;
    logic             in_valid = 1'b0;
    logic [7:0]       in_index = '0;
    logic [7:0]       in_byte = '0;
    logic             done, csum_ok, dec_err, ecc_present;
    logic [7:0]       row_bits, col_bits, rank_count, dev_banks;
    logic [7:0]       burst_mask, cas_mask, tck_cl3_tenths, tck_cl2_tenths;
    logic [CNT_W-1:0] trp_clk, trrd_clk, trcd_clk, tras_clk;

    always #2.5 clk = ~clk;

    spd_decoder #(.ITER_MAX(ITER_MAX), .CNT_W(CNT_W)) dut (
        .clk(clk), .rst_n(rst_n), .period_tenths(period_tenths),
        .in_valid(in_valid), .in_index(in_index), .in_byte(in_byte),
        .done(done), .csum_ok(csum_ok), .dec_err(dec_err),
        .row_bits(row_bits), .col_bits(col_bits), .rank_count(rank_count),
        .dev_banks(dev_banks), .ecc_present(ecc_present),
        .burst_mask(burst_mask), .cas_mask(cas_mask),
        .tck_cl3_tenths(tck_cl3_tenths), .tck_cl2_tenths(tck_cl2_tenths),
        .trp_clk(trp_clk), .trrd_clk(trrd_clk), .trcd_clk(trcd_clk), .tras_clk(tras_clk)
    );

    typedef struct {
        int row, col, ranks, dbanks, ecc, bl, cl, tck3, tck2;
        int trp, trrd, trcd, tras, csum, err, lat, stamp;
    } exp_t;

    exp_t        exp_q[$];
    exp_t        last_good;
    logic [7:0]  img [256];
    int          cyc = 0;
    int          n_chk = 0;
    int          n_fail = 0;

    always @(posedge clk) cyc <= cyc + 1;

    task automatic chk(input string tag, input int act, input int expv);
        n_chk++;
        if (act != expv) begin
            n_fail++;
            $display("FAIL %s: actual %0d expected %0d", tag, act, expv);
        end
    endtask

    function automatic int to_clk(input int ns, input int p);
        int c;
        if (ns == 0) return 0;
        if (p == 0) return ITER_MAX;
        c = (ns * 10 + p - 1) / p;
        return (c > ITER_MAX) ? ITER_MAX : c;
    endfunction

    function automatic int tck(input int b);
        return (b / 16) * 10 + (b % 16);
    endfunction

    function automatic int img_sum();
        int s = 0;
        for (int i = 0; i <= 62; i++) s += img[i];
        return s % 256;
    endfunction

    task automatic fix_sum();
        img[63] = 8'(img_sum());
    endtask

    task automatic build_image(input bit fast, input bit two_rank, input bit ecc);
        for (int i = 0; i < 256; i++) img[i] = 8'hFF;
        for (int i = 36; i <= 61; i++) img[i] = 8'h00;
        img[0] = 8'h80; img[1] = 8'h08; img[2] = 8'h04; img[3] = 8'h0C;
        img[4] = 8'h0A; img[5] = two_rank ? 8'h02 : 8'h01;
        img[6] = ecc ? 8'h48 : 8'h40; img[7] = 8'h00; img[8] = 8'h01;
        img[9] = fast ? 8'h75 : 8'hA0; img[10] = fast ? 8'h54 : 8'h60;
        img[11] = ecc ? 8'h02 : 8'h00; img[12] = 8'h80; img[13] = 8'h08;
        img[14] = ecc ? 8'h08 : 8'h00; img[15] = 8'h01; img[16] = 8'h0F;
        img[17] = 8'h04; img[18] = 8'h06; img[19] = 8'h01; img[20] = 8'h01;
        img[21] = 8'h00; img[22] = 8'h0E; img[23] = 8'hA0; img[24] = 8'h60;
        img[27] = 8'h14; img[28] = fast ? 8'h0F : 8'h10; img[29] = 8'h14;
        img[30] = 8'h2D; img[31] = 8'h20; img[32] = 8'h15; img[33] = 8'h08;
        img[34] = 8'h15; img[35] = 8'h08; img[62] = 8'h12;
        img[126] = 8'h64; img[127] = fast ? 8'hAF : 8'hFF;
        fix_sum();
    endtask

    function automatic exp_t predict(input int p);
        exp_t e;
        bit   t_ok = (img[2] == 8'h04);
        bit   s_ok = (img_sum() == int'(img[63]));
        if (t_ok && s_ok) begin
            e.row = img[3]; e.col = img[4]; e.ranks = img[5]; e.dbanks = img[17];
            e.ecc = (img[11] == 8'h02) ? 1 : 0;
            e.bl = img[16]; e.cl = img[18];
            e.tck3 = tck(img[9]); e.tck2 = tck(img[23]);
            e.trp = to_clk(img[27], p); e.trrd = to_clk(img[28], p);
            e.trcd = to_clk(img[29], p); e.tras = to_clk(img[30], p);
            e.csum = 1; e.err = 0; e.lat = LAT_OK;
            last_good = e;
        end else begin
            e = last_good;
            e.csum = s_ok ? 1 : 0; e.err = 1; e.lat = LAT_BAD;
        end
        return e;
    endfunction

    // Driver: stream one image, queue the prediction, optionally keep sending junk
    task automatic send_image(input int p, input int junk_beats);
        exp_t e;
        e = predict(p);
        @(negedge clk);
        period_tenths = 8'(p);
        for (int i = 0; i < 256; i++) begin
            if (i != 0) @(negedge clk);
            in_valid = 1'b1; in_index = 8'(i); in_byte = img[i];
        end
        @(negedge clk);
        e.stamp = cyc;
        exp_q.push_back(e);
        for (int j = 0; j < junk_beats; j++) begin
            in_valid = 1'b1;
            in_index = (j % 3 == 0) ? 8'd255 : 8'(j);
            in_byte = 8'(j * 37 + 1);
            @(negedge clk);
        end
        in_valid = 1'b0;
        while (exp_q.size() != 0) @(negedge clk);
    endtask

    // Monitor: compare published results against the queue
    initial begin
        forever begin
            @(negedge clk);
            if (rst_n && done) begin
                if (exp_q.size() == 0) begin
                    chk("R11 unexpected done", 1, 0);
                end else begin
                    exp_t e;
                    e = exp_q.pop_front();
                    chk("R9 latency", cyc - e.stamp, e.lat);
                    chk("R2 csum_ok", int'(csum_ok), e.csum);
                    chk("R3 dec_err", int'(dec_err), e.err);
                    chk("R5 row_bits", int'(row_bits), e.row);
                    chk("R5 col_bits", int'(col_bits), e.col);
                    chk("R5 rank_count", int'(rank_count), e.ranks);
                    chk("R5 dev_banks", int'(dev_banks), e.dbanks);
                    chk("R5 ecc_present", int'(ecc_present), e.ecc);
                    chk("R6 burst_mask", int'(burst_mask), e.bl);
                    chk("R6 cas_mask", int'(cas_mask), e.cl);
                    chk("R7 tck_cl3", int'(tck_cl3_tenths), e.tck3);
                    chk("R7 tck_cl2", int'(tck_cl2_tenths), e.tck2);
                    chk("R8 trp_clk", int'(trp_clk), e.trp);
                    chk("R8 trrd_clk", int'(trrd_clk), e.trrd);
                    chk("R8 trcd_clk", int'(trcd_clk), e.trcd);
                    chk("R8 tras_clk", int'(tras_clk), e.tras);
                    if (e.err != 0) chk("R4 held values", int'(tras_clk), last_good.tras);
                end
            end else if (rst_n) begin
                chk("R9 done low between results", int'(done), 0);
            end
        end
    end

    initial begin
        repeat (100000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

    initial begin
        last_good = '{default: 0};
        repeat (4) @(negedge clk);
        chk("R1 done", int'(done), 0);
        chk("R1 csum_ok", int'(csum_ok), 0);
        chk("R1 dec_err", int'(dec_err), 0);
        chk("R1 row_bits", int'(row_bits), 0);
        chk("R1 tras_clk", int'(tras_clk), 0);
        rst_n = 1'b1;

        // R5 R6 R7 R8: faster module, 7.5 ns clock
        build_image(1'b1, 1'b0, 1'b0);
        send_image(75, 0);

        // R5: two ranks with check bits, 10 ns clock
        build_image(1'b0, 1'b1, 1'b1);
        send_image(100, 0);

        // R8: same image, 5 ns clock
        send_image(50, 0);

        // R10: vendor/user area and an undecoded low byte altered
        build_image(1'b1, 1'b0, 1'b0);
        for (int i = 64; i < 256; i++) img[i] = 8'(i ^ 8'h5A);
        img[40] = 8'h3C;
        fix_sum();
        send_image(75, 0);

        // R7 R8: saturation, zero, exact division, odd nibble code
        build_image(1'b1, 1'b0, 1'b0);
        img[9] = 8'hF9; img[23] = 8'h10;
        img[27] = 8'h00; img[28] = 8'h0F; img[29] = 8'h14; img[30] = 8'hFF;
        img[16] = 8'h0B; img[18] = 8'h04;
        fix_sum();
        send_image(10, 0);

        // R2 R4: corrupted checksum
        build_image(1'b0, 1'b1, 1'b0);
        img[63] = img[63] ^ 8'h01;
        send_image(100, 0);

        // R3 R4: wrong memory type with a consistent checksum
        build_image(1'b0, 1'b1, 1'b0);
        img[2] = 8'h02;
        fix_sum();
        send_image(100, 0);

        // R11: junk beats, including index 255, while decoding
        build_image(1'b0, 1'b1, 1'b1);
        send_image(75, 30);

        // R8: awkward period
        build_image(1'b1, 1'b1, 1'b1);
        send_image(7, 0);

        repeat (5) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_chk, n_fail);
        $finish;
    end

endmodule